// File: doc/BRIEF.md
# Two-Wire Serial Shift Unit

This block is a bit-level serial engine for a two-wire bus, advanced entirely by a controller. Each strobe from the controller inverts the serial clock latch. A rising clock edge captures the data line into a holding bit. A falling clock edge shifts the 8-bit data register one place to the left and moves the captured bit into its LSB. The register's MSB drives the data line. The controller also has a data-line latch. When that latch is low it forces the line low, which is how start and stop conditions are produced.

A 4-bit edge counter advances on every strobe, so it counts both clock edges. Preloading the counter sets how long a transfer runs. A preload of 0 wraps after 16 edges, which is a full byte. A preload of 14 wraps after 2 edges, which is a single acknowledge bit. The wrap sets a sticky overflow flag. Three more sticky flags record:
- a start condition seen on the bus,
- a stop condition seen on the bus,
- a data collision.

A single status write clears chosen flags and loads the counter in the same cycle. Both pads are open-drain. Each has a drive-low output to the pad and a sampled input from the pad.

Top module: `tw_shift_unit`

## Requirements
- R1: A cycle with `tick` high inverts the clock latch. A cycle with `scl_wr` high loads the latch from `scl_wval` and takes precedence over `tick`. `scl_drive_low` is the inverse of the latch.
- R2: The edge counter is `status_q[3:0]`. It increments by one on every `tick` cycle, on rising and falling clock edges alike.
- R3: A `tick` that moves the counter from 15 to 0 sets the overflow flag `status_q[6]`. So a preload of 0 sets it after 16 ticks, and a preload of 14 sets it after 2 ticks.
- R4: On a `tick` with the clock latch low (a rising edge), `sda_in` is captured into a holding bit. On a `tick` with the latch high (a falling edge), `data_q` shifts left and the holding bit enters bit 0. `dat_wr` loads `dat_wdata` and takes precedence over the shift. In every other cycle `data_q` holds its value.
- R5: In a `sts_wr` cycle:
  - each one among `sts_wdata[7:4]` clears the flag at the same position (7 start, 6 overflow, 5 stop, 4 collision);
  - `sts_wdata[3:0]` loads the counter, and this load takes precedence over `tick`;
  - a flag set in that same cycle stays set.
- R6: `sda_drive_low` is high unless both `port_sda` and `data_q[7]` are high.
- R7: The start flag `status_q[7]` sets when `sda_in` is low, was high in the previous cycle, and `scl_in` is high. The stop flag `status_q[5]` sets when `sda_in` is high, was low in the previous cycle, and `scl_in` is high.
- R8: The collision flag `status_q[4]` sets on a rising-edge `tick` when `data_q[7]` and `port_sda` are both high but `sda_in` is low.
- R9: After reset:
  - `data_q` is 0xFF;
  - the counter and all flags are 0;
  - the clock latch is high, so neither line is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Clock strobe: toggle the serial clock latch |
| scl_wr | input | 1 | Direct write of the clock latch |
| scl_wval | input | 1 | Value for the clock latch write |
| port_sda | input | 1 | Data-line latch; low forces the line low |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 8 | Flag clear mask [7:4], counter preload [3:0] |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Data register write value |
| sda_in | input | 1 | Sampled level of the data pad |
| scl_in | input | 1 | Sampled level of the clock pad |
| sda_drive_low | output | 1 | Pull the data pad low |
| scl_drive_low | output | 1 | Pull the clock pad low |
| data_q | output | 8 | Shift register contents |
| status_q | output | 8 | {start, overflow, stop, collision, counter[3:0]} |

## Verification
The properties assume that `sda_in` and `scl_in` follow the pads, which are pulled low either by this block or by a bus peer. They also assume that the controller issues at most one `tick` per cycle.

The stimulus holds these pad levels by resolving both lines in the bench from the block's drive outputs and a modelled peer. The peer changes its pull on the data line only while the clock latch is low, so the only start or stop conditions are the deliberate ones. Strobes that coincide with register writes are applied on purpose, to exercise the precedence rules.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int FLAG_N = 4;
    // flag order inside the status nibble, MSB first
    typedef struct packed {
        logic start;
        logic ovf;
        logic stop;
        logic coll;
    } tw_flags_t;
endpackage

// File: rtl/tw_edge_ctr.sv
module tw_edge_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (load) begin
            st_d.cnt = load_val;
        end else if (step) begin
            st_d.cnt = st_q.cnt + ONE;
            wrap     = (st_q.cnt == FULL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/tw_shifter.sv
module tw_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise,
    input  logic          fall,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          sda_in,
    output logic [DW-1:0] data,
    output logic          msb
);
    typedef struct packed {
        logic [DW-1:0] sh;
        logic          hold;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rise) st_d.hold = sda_in;
        if (wr) begin
            st_d.sh = wdata;
        end else if (fall) begin
            st_d.sh = {st_q.sh[DW-2:0], st_q.hold};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh   <= '1;
            st_q.hold <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign data = st_q.sh;
    assign msb  = st_q.sh[DW-1];
endmodule

// File: rtl/tw_line_watch.sv
module tw_line_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_in,
    input  logic scl_in,
    output logic start_seen,
    output logic stop_seen
);
    typedef struct packed {
        logic sda_prev;
    } lw_t;

    lw_t st_d, st_q;

    always_comb begin
        st_d.sda_prev = sda_in;
        start_seen    = scl_in &  st_q.sda_prev & ~sda_in;
        stop_seen     = scl_in & ~st_q.sda_prev &  sda_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.sda_prev <= 1'b1;
        else        st_q          <= st_d;
    end
endmodule

// File: rtl/tw_shift_unit.sv
module tw_shift_unit #(
    parameter int DW    = 8,
    parameter int CNT_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      scl_wr,
    input  logic                      scl_wval,
    input  logic                      port_sda,
    input  logic                      sts_wr,
    input  logic [CNT_W+tw_pkg::FLAG_N-1:0] sts_wdata,
    input  logic                      dat_wr,
    input  logic [DW-1:0]             dat_wdata,
    input  logic                      sda_in,
    input  logic                      scl_in,
    output logic                      sda_drive_low,
    output logic                      scl_drive_low,
    output logic [DW-1:0]             data_q,
    output logic [CNT_W+tw_pkg::FLAG_N-1:0] status_q
);
    import tw_pkg::*;

    typedef struct packed {
        logic      scl;
        tw_flags_t flags;
    } top_t;

    top_t st_d, st_q;

    logic             rise, fall, wrap, msb, start_seen, stop_seen, coll_hit;
    logic [CNT_W-1:0] cnt;
    tw_flags_t        clr_mask, set_mask;

    assign rise = tick & ~st_q.scl;
    assign fall = tick &  st_q.scl;

    tw_edge_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .step(tick), .load(sts_wr),
        .load_val(sts_wdata[CNT_W-1:0]), .cnt(cnt), .wrap(wrap)
    );

    tw_shifter #(.DW(DW)) u_shf (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .wr(dat_wr),
        .wdata(dat_wdata), .sda_in(sda_in), .data(data_q), .msb(msb)
    );

    tw_line_watch u_lw (
        .clk(clk), .rst_n(rst_n), .sda_in(sda_in), .scl_in(scl_in),
        .start_seen(start_seen), .stop_seen(stop_seen)
    );

    always_comb begin
        coll_hit = rise & msb & port_sda & ~sda_in;
        clr_mask = sts_wr ? tw_flags_t'(sts_wdata[CNT_W +: FLAG_N]) : '0;
        set_mask = '{start: start_seen, ovf: wrap, stop: stop_seen, coll: coll_hit};

        st_d = st_q;
        if (scl_wr)    st_d.scl = scl_wval;
        else if (tick) st_d.scl = ~st_q.scl;
        st_d.flags = (st_q.flags & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.scl   <= 1'b1;
            st_q.flags <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_drive_low = ~(port_sda & msb);
    assign scl_drive_low = ~st_q.scl;
    assign status_q      = {st_q.flags, cnt};
endmodule

// File: rtl/tw_shift_unit_chk.sv
module tw_shift_unit_chk #(
    parameter int DW    = 8,
    parameter int CNT_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic                scl_wr,
    input logic                scl_wval,
    input logic                port_sda,
    input logic                sts_wr,
    input logic [CNT_W+3:0]    sts_wdata,
    input logic                dat_wr,
    input logic [DW-1:0]       dat_wdata,
    input logic                sda_in,
    input logic                scl_in,
    input logic                sda_drive_low,
    input logic                scl_drive_low,
    input logic [DW-1:0]       data_q,
    input logic [CNT_W+3:0]    status_q
);
    logic [CNT_W-1:0] cnt_now, cnt_next;
    assign cnt_now  = status_q[CNT_W-1:0];
    assign cnt_next = cnt_now + {{(CNT_W-1){1'b0}}, 1'b1};

    AST_TICK_FLIPS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !scl_wr |=> scl_drive_low != $past(scl_drive_low)); // R1
    AST_SCL_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        scl_wr |=> scl_drive_low == !$past(scl_wval)); // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !sts_wr |=> cnt_now == $past(cnt_next)); // R2
    AST_WRAP_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !sts_wr && cnt_now == {CNT_W{1'b1}} |=> status_q[CNT_W+2]); // R3
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !dat_wr |=> $stable(data_q)); // R4
    AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        dat_wr |=> data_q == $past(dat_wdata)); // R4
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sts_wr |=> cnt_now == $past(sts_wdata[CNT_W-1:0])); // R5
    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sts_wr && sts_wdata[CNT_W+2] |=> !status_q[CNT_W+2]); // R5
    AST_SDA_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        !port_sda |-> sda_drive_low); // R6
    AST_COLL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        tick && scl_drive_low && data_q[DW-1] && port_sda && !sda_in |=> status_q[CNT_W]); // R8
endmodule

bind tw_shift_unit tw_shift_unit_chk #(.DW(DW), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .scl_wr(scl_wr), .scl_wval(scl_wval),
    .port_sda(port_sda), .sts_wr(sts_wr), .sts_wdata(sts_wdata), .dat_wr(dat_wr),
    .dat_wdata(dat_wdata), .sda_in(sda_in), .scl_in(scl_in),
    .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low),
    .data_q(data_q), .status_q(status_q)
);

// File: tb/sim_tw_shift_unit.sv
`timescale 1ns/1ps
module sim_tw_shift_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 0, scl_wr = 0, scl_wval = 0, port_sda = 1;
    logic       sts_wr = 0, dat_wr = 0, slave_low = 0;
    logic [7:0] sts_wdata = 0, dat_wdata = 0;
    logic       sda_in, scl_in, sda_drive_low, scl_drive_low;
    logic [7:0] data_q, status_q;
    int         checks = 0, fails = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    assign sda_in = !sda_drive_low && !slave_low;
    assign scl_in = !scl_drive_low;

    tw_shift_unit u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .scl_wr(scl_wr), .scl_wval(scl_wval),
        .port_sda(port_sda), .sts_wr(sts_wr), .sts_wdata(sts_wdata), .dat_wr(dat_wr),
        .dat_wdata(dat_wdata), .sda_in(sda_in), .scl_in(scl_in),
        .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low),
        .data_q(data_q), .status_q(status_q)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_scl, m_cnt, m_sh, m_hold, m_prev, m_start, m_ovf, m_stop, m_coll;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_scl = 1; m_cnt = 0; m_sh = 255; m_hold = 1; m_prev = 1;
            m_start = 0; m_ovf = 0; m_stop = 0; m_coll = 0;
        end else begin
            int line, msb, rising, falling, n_start, n_stop, n_coll, n_ovf;
            msb     = (m_sh >> 7) & 1;
            line    = (port_sda && msb && !slave_low) ? 1 : 0;
            rising  = (tick && m_scl == 0) ? 1 : 0;
            falling = (tick && m_scl == 1) ? 1 : 0;
            n_start = (m_scl == 1 && m_prev == 1 && line == 0) ? 1 : 0;
            n_stop  = (m_scl == 1 && m_prev == 0 && line == 1) ? 1 : 0;
            n_coll  = (rising && msb == 1 && port_sda && line == 0) ? 1 : 0;
            n_ovf   = (tick && !sts_wr && m_cnt == 15) ? 1 : 0;
            if (sts_wr) begin
                if (sts_wdata[7]) m_start = 0;
                if (sts_wdata[6]) m_ovf = 0;
                if (sts_wdata[5]) m_stop = 0;
                if (sts_wdata[4]) m_coll = 0;
                m_cnt = sts_wdata[3:0];
            end else if (tick) m_cnt = (m_cnt + 1) % 16;
            if (n_start) m_start = 1;
            if (n_stop)  m_stop = 1;
            if (n_coll)  m_coll = 1;
            if (n_ovf)   m_ovf = 1;
            if (dat_wr) m_sh = dat_wdata;
            else if (falling) m_sh = ((m_sh << 1) | m_hold) & 255;
            if (rising) m_hold = line;
            if (scl_wr) m_scl = scl_wval;
            else if (tick) m_scl = 1 - m_scl;
            m_prev = line;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1 scl_drive_low", scl_drive_low, 1 - m_scl);
            chk("R2 counter", status_q[3:0], m_cnt);
            chk("R3 overflow", status_q[6], m_ovf);
            chk("R4 data", data_q, m_sh);
            chk("R6 sda_drive_low", sda_drive_low, (port_sda && ((m_sh >> 7) & 1)) ? 0 : 1);
            chk("R7 start", status_q[7], m_start);
            chk("R7 stop", status_q[5], m_stop);
            chk("R8 collision", status_q[4], m_coll);
        end
    end

    task automatic drv;  // advance to just after the next edge
        @(posedge clk); #1;
    endtask
    task automatic pulse_tick;
        tick = 1; drv(); tick = 0;
    endtask
    task automatic wr_sts(input logic [7:0] v);
        sts_wr = 1; sts_wdata = v; drv(); sts_wr = 0;
    endtask
    task automatic wr_dat(input logic [7:0] v);
        dat_wr = 1; dat_wdata = v; drv(); dat_wr = 0;
    endtask

    initial begin
        #2000000;
        checks++; fails++;
        $display("FAIL watchdog R9 act=hung exp=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R9 reset data", data_q, 8'hFF);
        chk("R9 reset status", status_q, 8'h00);
        chk("R9 reset scl", scl_drive_low, 0);
        chk("R9 reset sda", sda_drive_low, 0);

        // start condition: data latch low while clock high
        drv(); port_sda = 0; drv(); drv();
        @(negedge clk);
        chk("R7 start seen", status_q[7], 1);
        chk("R6 forced low", sda_drive_low, 1);
        drv(); scl_wval = 0; scl_wr = 1; drv(); scl_wr = 0;
        port_sda = 1; drv();
        @(negedge clk);
        chk("R7 no stop while clock low", status_q[5], 0);

        // full byte out: preload 0, 16 edges
        wr_sts(8'hF0);
        wr_dat(8'hA5);
        for (int i = 0; i < 16; i++) begin
            pulse_tick();
            if (i == 14) begin
                @(negedge clk);
                chk("R3 no overflow at 15 edges", status_q[6], 0);
            end
        end
        @(negedge clk);
        chk("R3 overflow after 16 edges", status_q[6], 1);
        chk("R2 counter wrapped", status_q[3:0], 0);
        chk("R4 byte echoed", data_q, 8'hA5);
        chk("R8 no collision on clean write", status_q[4], 0);

        // one-bit acknowledge: preload 14, peer pulls low
        wr_dat(8'hFF);
        wr_sts(8'h4E);
        @(negedge clk);
        chk("R5 overflow cleared and counter loaded", status_q[6:0], 7'h0E);
        slave_low = 1;
        pulse_tick();
        @(negedge clk);
        chk("R3 no overflow after one edge", status_q[6], 0);
        pulse_tick();
        slave_low = 0;
        @(negedge clk);
        chk("R3 overflow after 2 edges", status_q[6], 1);
        chk("R4 ack shifted in", data_q, 8'hFE);
        chk("R8 collision on ack", status_q[4], 1);

        // receive 0x3C
        wr_dat(8'hFF);
        wr_sts(8'hF0);
        @(negedge clk);
        chk("R5 all flags cleared", status_q[7:4], 0);
        for (int b = 7; b >= 0; b--) begin
            slave_low = !(8'h3C >> b & 1);
            pulse_tick();
            pulse_tick();
        end
        slave_low = 0;
        @(negedge clk);
        chk("R4 received byte", data_q, 8'h3C);
        chk("R8 collision on received zero", status_q[4], 1);
        chk("R2 counter after 16", status_q[3:0], 0);

        // stop condition
        wr_dat(8'hFF);
        port_sda = 0; drv();
        scl_wval = 1; scl_wr = 1; drv(); scl_wr = 0;
        drv(); port_sda = 1; drv(); drv();
        @(negedge clk);
        chk("R7 stop seen", status_q[5], 1);
        chk("R1 scl written high", scl_drive_low, 0);

        // precedence: status load beats tick, data load beats shift
        tick = 1; sts_wr = 1; sts_wdata = 8'h05; drv(); tick = 0; sts_wr = 0;
        @(negedge clk);
        chk("R5 load wins over tick", status_q[3:0], 5);
        chk("R1 tick toggled clock", scl_drive_low, 1);
        tick = 1; dat_wr = 1; dat_wdata = 8'h5A; drv(); tick = 0; dat_wr = 0;
        @(negedge clk);
        chk("R4 write wins over shift", data_q, 8'h5A);
        chk("R2 counter step", status_q[3:0], 6);
        drv(); drv();
        @(negedge clk);
        chk("R4 data held", data_q, 8'h5A);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule